// File: doc/BRIEF.md
# Video RAM Memory-Operation Engine

This block sits between a video slot scheduler and a dual-port video DRAM. It carries out one memory operation at a time, and every operation takes exactly four clock cycles, whatever its kind. An operation can be one of four kinds: a serial-port fetch of a 32-bit word for rendering, a random-port read or write for the host CPU, an empty host slot, or a refresh. The engine multiplexes row and column addresses onto a narrow address bus. The bits of the logical address are permuted on the way, so that the two byte-lane bits sit in the column and not in the row. The engine also generates the row, column and write strobes in the order that each kind of operation needs.

Requests arrive on a valid/ready stream. `op_ready` is high while the engine is idle and during the last cycle of an operation, so a scheduler that holds `op_valid` high gets back-to-back operations with no gap. Results leave on two valid-only pulse outputs, because the DRAM timing is fixed and cannot be stalled. The consumer has to take each pulse in the cycle it appears. The bus delivers serial-port data during the operation that follows the fetch. The engine therefore keeps the fetch pending and releases it, together with its tag, when the next operation completes. Host read data is returned at the end of its own operation.

Top module: `vram_op_engine`

## Requirements
- R1: An operation is accepted on a clock edge where `op_valid` and `op_ready` are both high. `op_ready` is high while the engine is idle and in cycle 4 of an operation, and low in cycles 1 to 3. Each accepted operation occupies exactly the four cycles that follow its acceptance. With no new request, the engine returns to idle.
- R2: Operation codes on `op_type`: 0 is serial fetch, 1 is host read, 2 is host write, 3 is empty host slot, and 4 to 7 are refresh. For codes 0 to 3, `ras_n` is low in cycles 1 to 4 and `cas_n` is low in cycles 2 to 4.
- R3: A refresh drives `cas_n` low in cycles 1 to 4 and `ras_n` low only in cycles 2 to 4 (column before row). During a refresh, `ma` is zero, `we_n` is high and `ser_sel` is low.
- R4: `ma` carries the row in cycle 1 and the column in cycles 2 to 4. Row bit i is logical address bit i+2, for i = 0..7. Column bits 0 and 1 are logical bits 0 and 1, and column bit j is logical bit j+8, for j = 2..7.
- R5: A host write drives `we_n` low and `wr_oe` high in cycles 2 to 4, with `wr_data` holding the accepted write data. At every other time `we_n` is high, `wr_oe` is low and `wr_data` is zero.
- R6: A host read produces a one-cycle pulse on `host_valid` in the cycle after its cycle 4. `host_data` carries the value of `rdata_rnd` at the end of cycle 4. No other kind of operation raises `host_valid`.
- R7: A serial fetch produces a one-cycle pulse on `fetch_valid` in the cycle after cycle 4 of the next accepted operation, of any kind. `fetch_data` carries `rdata_ser` at that edge and `fetch_tag` carries the fetch's own `op_tag`. Idle gaps in between do not release the fetch.
- R8: An empty host slot (code 3) performs a read at the address of the last accepted operation that carried an address (codes 0, 1 or 2). That address is zero after reset, and a refresh leaves it unchanged.
- R9: `ser_sel` is high in cycles 1 to 4 of serial fetches only.
- R10: While reset is active and after it is released, the engine is idle: strobes are high, `ma` is zero, both result pulses are low and `op_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation request valid |
| op_ready | output | 1 | Engine can accept an operation this cycle |
| op_type | input | 3 | Operation code (see R2) |
| op_addr | input | 16 | Logical byte address |
| op_tag | input | 2 | Fetch tag returned with serial data |
| op_wdata | input | 32 | Host write data |
| ma | output | 8 | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ser_sel | output | 1 | Operation targets the serial port |
| wr_data | output | 32 | Write data to the random port |
| wr_oe | output | 1 | Write data driver enable |
| rdata_rnd | input | 32 | Random-port read data bus |
| rdata_ser | input | 32 | Serial-port read data bus |
| fetch_valid | output | 1 | Serial fetch result pulse |
| fetch_tag | output | 2 | Tag of the completed fetch |
| fetch_data | output | 32 | Serial fetch data |
| host_valid | output | 1 | Host read result pulse |
| host_data | output | 32 | Host read data |

## Verification
The hardest case to reach is a serial fetch whose data stays pending across an idle gap. The data must then be released by an operation of a different kind, often a refresh with reserved codes 5 to 7, and it must keep its own tag rather than the tag of the operation that released it. A related hard case is an empty host slot that comes right after reset or right after a refresh, where the engine has to pick the right prior address. The stimulus therefore mixes back-to-back fetches, deliberate idle gaps of several lengths, refresh-then-empty-slot pairs and an empty slot as the very first operation. Both read buses change value every cycle, so a capture one cycle early or late returns a visibly wrong word.

// File: rtl/vram_eng_pkg.sv
package vram_eng_pkg;
  typedef enum logic [2:0] {
    OP_SER   = 3'd0,
    OP_HRD   = 3'd1,
    OP_HWR   = 3'd2,
    OP_HIDLE = 3'd3,
    OP_REF   = 3'd4
  } op_e;

  // codes 4..7 all decode as refresh
  function automatic logic is_refresh(input logic [2:0] t);
    return t[2];
  endfunction
endpackage

// File: rtl/vram_op_seq.sv
module vram_op_seq
  import vram_eng_pkg::*;
#(
  parameter int OP_CYC = 4,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_type,
  input  logic [TAG_W-1:0]  op_tag,
  input  logic [DATA_W-1:0] op_wdata,
  output logic              op_ready,
  output logic              accept,
  output logic [OP_CYC-1:0] cyc,
  output logic [2:0]        cur_type,
  output logic [TAG_W-1:0]  cur_tag,
  output logic [DATA_W-1:0] cur_wdata
);
  localparam int LAST = OP_CYC - 1;

  logic busy;

  assign busy     = |cyc;
  assign op_ready = !busy || cyc[LAST];
  assign accept   = op_valid && op_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc       <= '0;
      cur_type  <= 3'd0;
      cur_tag   <= '0;
      cur_wdata <= '0;
    end else if (accept) begin
      cyc       <= {{(OP_CYC-1){1'b0}}, 1'b1};
      cur_type  <= op_type;
      cur_tag   <= op_tag;
      cur_wdata <= op_wdata;
    end else begin
      cyc <= {cyc[LAST-1:0], 1'b0};
    end
  end

  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cyc));

  for (genvar i = 0; i < LAST; i++) begin : g_step_chk
    p_advance_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cyc[i] |=> cyc[i+1]);
  end

  p_hold_type_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cyc[LAST]) |=> $stable(cur_type));
endmodule

// File: rtl/vram_addr_map.sv
module vram_addr_map
  import vram_eng_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int MA_W   = 8,
  parameter int LANE_W = 2,
  parameter int OP_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [2:0]        op_type,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [OP_CYC-1:0] cyc,
  input  logic [2:0]        cur_type,
  output logic [MA_W-1:0]   ma
);
  logic [ADDR_W-1:0] cur_addr;
  logic [ADDR_W-1:0] prev_addr;
  logic [ADDR_W-1:0] perm;
  logic              carries_addr;

  assign carries_addr = !is_refresh(op_type) && (op_type != OP_HIDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      prev_addr <= '0;
    end else if (accept) begin
      if (carries_addr) begin
        cur_addr  <= op_addr;
        prev_addr <= op_addr;
      end else begin
        cur_addr  <= prev_addr;
      end
    end
  end

  // row half takes the bits above the byte lane, column half the rest
  for (genvar k = 0; k < ADDR_W; k++) begin : g_perm
    if (k < MA_W) begin : g_row
      assign perm[k] = cur_addr[k+LANE_W];
    end else if (k < MA_W + LANE_W) begin : g_lane
      assign perm[k] = cur_addr[k-MA_W];
    end else begin : g_high
      assign perm[k] = cur_addr[k];
    end
  end

  always_comb begin
    if (!(|cyc) || is_refresh(cur_type)) ma = '0;
    else if (cyc[0])                    ma = perm[MA_W-1:0];
    else                                ma = perm[ADDR_W-1:MA_W];
  end

  p_prev_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_refresh(op_type)) |=> $stable(prev_addr));

  p_idle_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_type == OP_HIDLE) |=> (cur_addr == $past(prev_addr)));
endmodule

// File: rtl/vram_strobe_gen.sv
module vram_strobe_gen
  import vram_eng_pkg::*;
#(
  parameter int OP_CYC = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_CYC-1:0] cyc,
  input  logic [2:0]        cur_type,
  input  logic [DATA_W-1:0] cur_wdata,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              ser_sel,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_oe
);
  logic busy, late, refr, wr;

  assign busy = |cyc;
  assign late = |cyc[OP_CYC-1:1];
  assign refr = is_refresh(cur_type);
  assign wr   = late && (cur_type == OP_HWR);

  assign ras_n   = !(busy && (refr ? late : 1'b1));
  assign cas_n   = !(busy && (refr ? 1'b1 : late));
  assign we_n    = !wr;
  assign wr_oe   = wr;
  assign wr_data = wr ? cur_wdata : '0;
  assign ser_sel = busy && (cur_type == OP_SER);

  p_we_inside_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!ras_n && !cas_n && wr_oe));

  p_cbr_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && ras_n) |-> is_refresh(cur_type));

  p_row_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && cas_n) |-> !is_refresh(cur_type));
endmodule

// File: rtl/vram_rd_return.sv
module vram_rd_return
  import vram_eng_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              last,
  input  logic [2:0]        cur_type,
  input  logic [TAG_W-1:0]  cur_tag,
  input  logic [DATA_W-1:0] rdata_rnd,
  input  logic [DATA_W-1:0] rdata_ser,
  output logic              fetch_valid,
  output logic [TAG_W-1:0]  fetch_tag,
  output logic [DATA_W-1:0] fetch_data,
  output logic              host_valid,
  output logic [DATA_W-1:0] host_data
);
  logic             pend;
  logic [TAG_W-1:0] pend_tag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend        <= 1'b0;
      pend_tag    <= '0;
      fetch_valid <= 1'b0;
      fetch_tag   <= '0;
      fetch_data  <= '0;
      host_valid  <= 1'b0;
      host_data   <= '0;
    end else if (last) begin
      host_valid  <= (cur_type == OP_HRD);
      if (cur_type == OP_HRD) host_data <= rdata_rnd;
      fetch_valid <= pend;
      if (pend) begin
        fetch_data <= rdata_ser;
        fetch_tag  <= pend_tag;
      end
      pend     <= (cur_type == OP_SER);
      pend_tag <= cur_tag;
    end else begin
      host_valid  <= 1'b0;
      fetch_valid <= 1'b0;
    end
  end

  p_fetch_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |=> !fetch_valid);

  p_host_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid |=> !host_valid);

  p_host_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_valid) |-> ($past(cur_type) == OP_HRD));
endmodule

// File: rtl/vram_op_engine.sv
module vram_op_engine
  import vram_eng_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int MA_W   = 8,
  parameter int LANE_W = 2,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 2,
  parameter int OP_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [2:0]        op_type,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [TAG_W-1:0]  op_tag,
  input  logic [DATA_W-1:0] op_wdata,
  output logic [MA_W-1:0]   ma,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              ser_sel,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_oe,
  input  logic [DATA_W-1:0] rdata_rnd,
  input  logic [DATA_W-1:0] rdata_ser,
  output logic              fetch_valid,
  output logic [TAG_W-1:0]  fetch_tag,
  output logic [DATA_W-1:0] fetch_data,
  output logic              host_valid,
  output logic [DATA_W-1:0] host_data
);
  logic              accept;
  logic [OP_CYC-1:0] cyc;
  logic [2:0]        cur_type;
  logic [TAG_W-1:0]  cur_tag;
  logic [DATA_W-1:0] cur_wdata;

  vram_op_seq #(.OP_CYC(OP_CYC), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_type(op_type),
    .op_tag(op_tag), .op_wdata(op_wdata), .op_ready(op_ready),
    .accept(accept), .cyc(cyc), .cur_type(cur_type), .cur_tag(cur_tag),
    .cur_wdata(cur_wdata)
  );

  vram_addr_map #(.ADDR_W(ADDR_W), .MA_W(MA_W), .LANE_W(LANE_W), .OP_CYC(OP_CYC)) u_amap (
    .clk(clk), .rst_n(rst_n), .accept(accept), .op_type(op_type),
    .op_addr(op_addr), .cyc(cyc), .cur_type(cur_type), .ma(ma)
  );

  vram_strobe_gen #(.OP_CYC(OP_CYC), .DATA_W(DATA_W)) u_strb (
    .clk(clk), .rst_n(rst_n), .cyc(cyc), .cur_type(cur_type),
    .cur_wdata(cur_wdata), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ser_sel(ser_sel), .wr_data(wr_data), .wr_oe(wr_oe)
  );

  vram_rd_return #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_ret (
    .clk(clk), .rst_n(rst_n), .last(cyc[OP_CYC-1]), .cur_type(cur_type),
    .cur_tag(cur_tag), .rdata_rnd(rdata_rnd), .rdata_ser(rdata_ser),
    .fetch_valid(fetch_valid), .fetch_tag(fetch_tag), .fetch_data(fetch_data),
    .host_valid(host_valid), .host_data(host_data)
  );

  p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (op_ready && ras_n && cas_n));
endmodule

// File: tb/vram_op_engine_bench.sv
module vram_op_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_type = 3'd0;
  logic [15:0] op_addr = 16'd0;
  logic [1:0]  op_tag = 2'd0;
  logic [31:0] op_wdata = 32'd0;
  logic [31:0] rdata_rnd = 32'd0;
  logic [31:0] rdata_ser = 32'd0;
  logic        op_ready, ras_n, cas_n, we_n, ser_sel, wr_oe;
  logic        fetch_valid, host_valid;
  logic [7:0]  ma;
  logic [1:0]  fetch_tag;
  logic [31:0] wr_data, fetch_data, host_data;

  always #2 clk = ~clk;

  vram_op_engine u_vram_op_engine (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_type(op_type), .op_addr(op_addr), .op_tag(op_tag), .op_wdata(op_wdata),
    .ma(ma), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ser_sel(ser_sel),
    .wr_data(wr_data), .wr_oe(wr_oe), .rdata_rnd(rdata_rnd), .rdata_ser(rdata_ser),
    .fetch_valid(fetch_valid), .fetch_tag(fetch_tag), .fetch_data(fetch_data),
    .host_valid(host_valid), .host_data(host_data)
  );

  int checks = 0;
  int fails  = 0;
  int ncyc   = 0;
  bit started = 0;

  task automatic check(input string rq, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %h exp %h at %0t", rq, what, got, exp, $time);
    end
  endtask

  // behavioural reference: cycle number within the operation, 0 = idle
  int          m_cnt = 0;
  logic [2:0]  m_type = 0;
  logic [15:0] m_addr = 0, m_prev = 0;
  logic [31:0] m_wdata = 0, m_fd = 0, m_hd = 0;
  logic [1:0]  m_ctag = 0, m_ptag = 0, m_ftag = 0;
  bit          m_pend = 0, m_fv = 0, m_hv = 0;

  always @(posedge clk) begin
    bit rdy;
    started = 1;
    if (!rst_n) begin
      m_cnt = 0; m_type = 0; m_addr = 0; m_prev = 0; m_pend = 0;
      m_fv = 0; m_hv = 0; m_wdata = 0;
    end else begin
      rdy = (m_cnt == 0) || (m_cnt == 4);
      m_fv = 0; m_hv = 0;
      if (m_cnt == 4) begin
        if (m_type == 3'd1) begin m_hv = 1; m_hd = rdata_rnd; end
        if (m_pend) begin m_fv = 1; m_fd = rdata_ser; m_ftag = m_ptag; end
        m_pend = (m_type == 3'd0);
        m_ptag = m_ctag;
      end
      if (op_valid && rdy) begin
        m_cnt = 1; m_type = op_type; m_ctag = op_tag; m_wdata = op_wdata;
        if (op_type == 3'd3) m_addr = m_prev;
        else if (op_type <= 3'd2) begin m_addr = op_addr; m_prev = op_addr; end
      end else if (m_cnt == 4 || m_cnt == 0) m_cnt = 0;
      else m_cnt = m_cnt + 1;
    end
  end

  always @(negedge clk) begin
    ncyc++;
    rdata_ser = ncyc * 32'h9E3779B1;
    rdata_rnd = ~(ncyc * 32'h85EBCA6B);
  end

  always @(negedge clk) begin
    bit busy, refr, wr;
    logic [7:0] ema;
    string rs;
    if (started) begin
      busy = (m_cnt != 0);
      refr = m_type[2];
      wr   = busy && m_type == 3'd2 && m_cnt >= 2;
      if (!busy || refr) ema = 8'h00;
      else if (m_cnt == 1) ema = m_addr[9:2];
      else ema = {m_addr[15:10], m_addr[1:0]};
      if (!rst_n) begin
        check("R10", "idle ras_n/cas_n/ready", {ras_n, cas_n, op_ready}, 3'b111);
        check("R10", "idle ma/pulses", {ma, fetch_valid, host_valid}, 10'd0);
      end else begin
        check("R1", "op_ready", op_ready, (m_cnt == 0) || (m_cnt == 4));
        rs = refr ? "R3" : "R2";
        check(rs, "ras_n", ras_n, !(busy && (refr ? m_cnt >= 2 : 1)));
        check(rs, "cas_n", cas_n, !(busy && (refr ? 1 : m_cnt >= 2)));
        rs = (busy && m_type == 3'd3) ? "R8" : (refr ? "R3" : "R4");
        check(rs, "ma", ma, ema);
        check("R5", "we_n/wr_oe", {we_n, wr_oe}, {!wr, wr});
        check("R5", "wr_data", wr_data, wr ? m_wdata : 32'd0);
        check("R9", "ser_sel", ser_sel, busy && m_type == 3'd0);
        check("R6", "host_valid", host_valid, m_hv);
        if (m_hv) check("R6", "host_data", host_data, m_hd);
        check("R7", "fetch_valid", fetch_valid, m_fv);
        if (m_fv) check("R7", "fetch tag/data", {fetch_tag, fetch_data}, {m_ftag, m_fd});
      end
    end
  end

  task automatic send(input logic [2:0] t, input logic [15:0] a,
                      input logic [1:0] g, input logic [31:0] w);
    op_valid = 1; op_type = t; op_addr = a; op_tag = g; op_wdata = w;
    while (!op_ready) @(negedge clk);
    @(negedge clk);
    op_valid = 0;
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 0;
    gap(5);
    rst_n = 1;
    gap(2);
    send(3'd3, 16'hFFFF, 2'd0, 32'h0);          // R8: empty slot after reset reads 0
    send(3'd0, 16'hA5C3, 2'd1, 32'h0);          // R7/R4 back to back fetches
    send(3'd0, 16'h1234, 2'd2, 32'h0);
    send(3'd1, 16'hBEEF, 2'd3, 32'h0);          // R6 host read releases fetch
    gap(7);
    send(3'd2, 16'h0F0F, 2'd0, 32'hCAFEF00D);   // R5
    send(3'd4, 16'h7777, 2'd0, 32'h0);          // R3 refresh
    send(3'd3, 16'h5555, 2'd0, 32'h0);          // R8 keeps 0F0F across refresh
    send(3'd0, 16'hC00C, 2'd3, 32'h0);
    gap(10);                                     // R7 fetch stays pending
    send(3'd7, 16'h0000, 2'd1, 32'h0);          // reserved code releases fetch tag 3
    send(3'd5, 16'h0001, 2'd0, 32'h0);
    send(3'd6, 16'h0002, 2'd0, 32'h0);
    send(3'd0, 16'h8001, 2'd2, 32'h0);
    send(3'd3, 16'h0000, 2'd0, 32'h0);
    for (int i = 0; i < 40; i++) begin
      send(3'((i * 5) % 8), 16'(i * 16'h1F3D + 16'h0101), 2'(i), 32'(i * 32'h01010101));
      if (i % 7 == 3) gap(i % 5 + 1);
    end
    gap(8);
    rst_n = 0;
    gap(3);
    rst_n = 1;
    gap(3);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog expired got hang exp finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule